// File: doc/BRIEF.md
# Dual-Bus Striping Serial Flash Shift Engine

This block is the shift engine of a serial flash master that controls two flash devices side by side. Both devices get the same serial clock and the same chip select. Each device has its own data bus of up to four lines. A request supplies a command byte, a byte address, a length, a direction, a bus choice, a striping flag, a line count and a clock divisor. The engine then sends one command byte and three address bytes, followed by the data phase. Write data arrives on a byte-wide valid/ready stream. Read data leaves on a second byte-wide valid/ready stream.

The engine has three bus choices. It can mirror every byte onto both buses, or it can use only the lower bus, or only the upper bus. With striping, each data byte slot carries two stream bytes: the even-numbered byte goes on the lower bus and the odd-numbered byte on the upper bus. Both devices receive the same halved address. Received striped data is put back in stream order, with the lower byte first. Each bus runs with 1, 2 or 4 lines per clock. When a stream stalls, the serial clock holds low between byte slots.

Top module: `dps_stripe_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, both output-enable vectors are 0, req_err is 0 and req_ready is 1.
- R2: sclk is 0 whenever cs_n is 1. Outgoing bits change only while sclk is low, and they are meant to be sampled on the rising sclk edge.
- R3: A transfer first sends the command byte and then three address bytes, most significant byte first, on every active bus. The address is req_addr, or req_addr shifted right by one when striping is on.
- R4: req_bus=2'b01 drives only the lower bus and req_bus=2'b10 drives only the upper bus; the other bus keeps its output enables at 0. req_bus=2'b11 or 2'b00 mirrors every byte onto both buses. Striping always uses both buses.
- R5: In a striped write, stream bytes 0, 2, 4, ... go out on the lower bus and bytes 1, 3, 5, ... on the upper bus.
- R6: In a striped read, each slot returns the lower-bus byte first and then the upper-bus byte. rx_valid rises only while cs_n is 0, and the byte is held under backpressure.
- R7: A non-striped read returns the upper-bus byte when req_bus=2'b10 and the lower-bus byte in every other case. The length counts bytes.
- R8: req_lanes=0 (single) sends MSB first on line 0 with enable 4'b0001 and samples line 1. req_lanes=1 (dual) sends and receives bit pairs, most significant pair first, on lines 1:0. req_lanes=2 (quad) sends and receives the high nibble first on lines 3:0.
- R9: A striped request with an odd address, an odd length or a zero length is rejected. req_err pulses for exactly one cycle, in the cycle after acceptance, and cs_n stays 1.
- R10: sclk stays high for D/2 system cycles, where D is clk_div with bit 0 cleared, and any value below 2 counts as 2.
- R11: Between the end of one transfer and the start of the next, cs_n stays 1 for at least D system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | 8 | Serial clock divisor, latched per request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, accepts a request |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 24 | Byte address |
| req_len | input | 12 | Data length in bytes |
| req_write | input | 1 | 1 = write data phase, 0 = read |
| req_bus | input | 2 | Bus choice: 01 lower, 10 upper, 11/00 both |
| req_stripe | input | 1 | Split data bytes across both buses |
| req_lanes | input | 2 | 0 single, 1 dual, 2 quad lines per bus |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Write byte taken |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Read byte offered |
| rx_ready | input | 1 | Read byte taken |
| rx_data | output | 8 | Read byte |
| sclk | output | 1 | Shared serial clock |
| cs_n | output | 1 | Shared chip select, active low |
| lo_dq_o | output | 4 | Lower bus output lines |
| lo_dq_oe | output | 4 | Lower bus output enables |
| lo_dq_i | input | 4 | Lower bus input lines |
| up_dq_o | output | 4 | Upper bus output lines |
| up_dq_oe | output | 4 | Upper bus output enables |
| up_dq_i | input | 4 | Upper bus input lines |

## Verification
The hardest case is a striped read under backpressure. The engine must hold the second byte of a slot while rx_ready is low, and the serial clock must stay stopped until both bytes have left. To create this case, the bench throttles rx_ready in a pattern that is unrelated to the slot timing. Each bench flash model counts falling sclk edges from the fall of cs_n and drives its own byte pattern in whichever line mode is in use. As a result, any swap of the lower and upper bytes, or any lost byte, shows up at rx_data.

// File: rtl/dps_pkg.sv
// Shared types for the dual-bus striping flash shift engine.
// Assumes at most four data lines per bus.
package dps_pkg;
    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2,
        LANE_RSV = 2'd3
    } lane_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_FETCH,
        ST_SHIFT,
        ST_DRAIN,
        ST_GAP
    } st_e;

    // Index of the last bit group in a byte for a line mode
    function automatic logic [2:0] last_group(lane_e m);
        case (m)
            LANE_X1: return 3'd7;
            LANE_X2: return 3'd3;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/dps_sclk_gen.sv
// Serial clock generator. While run is high, sclk toggles every
// half system cycles, starting low. rise/fall pulse in the cycle
// whose closing edge sets sclk high or low. Dropping run returns
// sclk low at once. Assumes half >= 1.
module dps_sclk_gen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half,
    output logic            sclk,
    output logic            rise,
    output logic            fall
);
    logic [DIVW-1:0] cnt_q;
    logic            wrap;

    assign wrap = run && (cnt_q == half - 1'b1);
    assign rise = wrap && !sclk;
    assign fall = wrap && sclk;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dps_lane_shifter.sv
// One bus's shift register. It sends a loaded byte in groups of
// 1, 2 or 4 bits, most significant group first. It collects the
// incoming groups into rx_byte. In single mode it sends on line 0
// and receives on line 1. shift and sample never coincide with load.
module dps_lane_shifter
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lane_e      lanes,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       drive,
    input  logic       shift,
    input  logic       sample,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_q;

    // Outgoing byte: load, then advance one group per falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_byte;
        end else if (shift) begin
            case (lanes)
                LANE_X1: tx_q <= {tx_q[6:0], 1'b0};
                LANE_X2: tx_q <= {tx_q[5:0], 2'b0};
                default: tx_q <= {tx_q[3:0], 4'b0};
            endcase
        end
    end

    // Incoming byte: clear on load, take one group per rising edge
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_byte <= '0;
        end else if (sample) begin
            case (lanes)
                LANE_X1: rx_byte <= {rx_byte[6:0], dq_i[1]};
                LANE_X2: rx_byte <= {rx_byte[5:0], dq_i[1:0]};
                default: rx_byte <= {rx_byte[3:0], dq_i};
            endcase
        end
    end

    // Line values and enables for the current group
    always_comb begin
        case (lanes)
            LANE_X1: begin dq_o = {3'b0, tx_q[7]};   dq_oe = drive ? 4'b0001 : 4'b0; end
            LANE_X2: begin dq_o = {2'b0, tx_q[7:6]}; dq_oe = drive ? 4'b0011 : 4'b0; end
            default: begin dq_o = tx_q[7:4];         dq_oe = drive ? 4'b1111 : 4'b0; end
        endcase
    end
endmodule

// File: rtl/dps_stripe_engine.sv
// Dual-bus serial flash shift engine. Each request sends a command
// slot, ABYTES address slots and a data phase over two buses that
// share sclk and cs_n. Bus choice: mirror, lower only, upper only.
// Striping puts two stream bytes in each data slot, the even byte
// on the lower bus. sclk stays low between slots while a stream
// stalls. A striped request with an odd address or length, or a
// zero length, is rejected. Assumes the divisor stays constant
// while a request is running (it is latched at acceptance).
module dps_stripe_engine
    import dps_pkg::*;
#(
    parameter int AW   = 24,
    parameter int LENW = 12,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] clk_div,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [7:0]      req_cmd,
    input  logic [AW-1:0]   req_addr,
    input  logic [LENW-1:0] req_len,
    input  logic            req_write,
    input  logic [1:0]      req_bus,
    input  logic            req_stripe,
    input  logic [1:0]      req_lanes,
    output logic            req_err,
    input  logic            tx_valid,
    output logic            tx_ready,
    input  logic [7:0]      tx_data,
    output logic            rx_valid,
    input  logic            rx_ready,
    output logic [7:0]      rx_data,
    output logic            sclk,
    output logic            cs_n,
    output logic [3:0]      lo_dq_o,
    output logic [3:0]      lo_dq_oe,
    input  logic [3:0]      lo_dq_i,
    output logic [3:0]      up_dq_o,
    output logic [3:0]      up_dq_oe,
    input  logic [3:0]      up_dq_i
);
    localparam int ABYTES = AW / 8;
    localparam int HW     = $clog2(ABYTES + 2);

    st_e             st_q;
    logic [7:0]      cmd_q;
    logic [AW-1:0]   addr_q;
    logic [LENW-1:0] left_q;
    logic [HW-1:0]   hdr_q;
    logic            write_q, stripe_q, upsel_q, part_q;
    logic [1:0]      act_q;
    lane_e           lanes_q;
    logic [DIVW-1:0] dv_q, gap_q;
    logic [2:0]      grp_q;
    logic            drive_q, rd_q, load_q, err_q;
    logic [7:0]      lo_byte_q, hi_byte_q;

    logic            bad_req, rise_w, fall_w, run_w, shift_w, grp_end;
    logic [DIVW-1:0] dv_w;
    logic [7:0]      hdr_byte;
    logic [1:0][3:0] dqi_w, dqo_w, dqoe_w;
    logic [1:0][7:0] rx_w;

    // Request screening and divisor sanitising
    always_comb begin
        bad_req  = req_stripe && (req_addr[0] || req_len[0] || (req_len == '0));
        dv_w     = (clk_div < DIVW'(2)) ? DIVW'(2) : {clk_div[DIVW-1:1], 1'b0};
        hdr_byte = (hdr_q == '0) ? cmd_q : addr_q[8*(ABYTES - int'(hdr_q)) +: 8];
        grp_end  = (grp_q == last_group(lanes_q));
    end

    assign run_w     = (st_q == ST_SHIFT) && !load_q;
    assign shift_w   = fall_w && !grp_end;
    assign req_ready = (st_q == ST_IDLE);
    assign tx_ready  = (st_q == ST_FETCH);
    assign rx_valid  = (st_q == ST_DRAIN);
    assign rx_data   = (stripe_q ? part_q : upsel_q) ? rx_w[1] : rx_w[0];
    assign cs_n      = (st_q == ST_IDLE) || (st_q == ST_GAP);
    assign req_err   = err_q;
    assign dqi_w     = {up_dq_i, lo_dq_i};
    assign lo_dq_o   = dqo_w[0];
    assign lo_dq_oe  = dqoe_w[0];
    assign up_dq_o   = dqo_w[1];
    assign up_dq_oe  = dqoe_w[1];

    dps_sclk_gen #(.DIVW(DIVW)) u_sclk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_w),
        .half (dv_q >> 1),
        .sclk (sclk),
        .rise (rise_w),
        .fall (fall_w)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bus
        dps_lane_shifter u_sh (
            .clk      (clk),
            .rst_n    (rst_n),
            .lanes    (lanes_q),
            .load     (load_q),
            .load_byte((b == 0) ? lo_byte_q : hi_byte_q),
            .drive    (drive_q && act_q[b]),
            .shift    (shift_w),
            .sample   (rise_w),
            .dq_i     (dqi_w[b]),
            .dq_o     (dqo_w[b]),
            .dq_oe    (dqoe_w[b]),
            .rx_byte  (rx_w[b])
        );
    end

    // Transfer sequencer: header slots, data slots, drain, gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;  cmd_q <= '0;  addr_q <= '0;  left_q <= '0;
            hdr_q <= '0;  write_q <= 1'b0;  stripe_q <= 1'b0;  upsel_q <= 1'b0;
            part_q <= 1'b0;  act_q <= '0;  lanes_q <= LANE_X1;  dv_q <= DIVW'(2);
            gap_q <= '0;  grp_q <= '0;  drive_q <= 1'b0;  rd_q <= 1'b0;
            load_q <= 1'b0;  err_q <= 1'b0;  lo_byte_q <= '0;  hi_byte_q <= '0;
        end else begin
            load_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    if (bad_req) begin
                        err_q <= 1'b1;
                    end else begin
                        cmd_q    <= req_cmd;
                        addr_q   <= req_stripe ? (req_addr >> 1) : req_addr;
                        left_q   <= req_stripe ? (req_len >> 1) : req_len;
                        hdr_q    <= '0;
                        write_q  <= req_write;
                        stripe_q <= req_stripe;
                        act_q    <= (req_stripe || req_bus == 2'b00) ? 2'b11 : req_bus;
                        upsel_q  <= !req_stripe && (req_bus == 2'b10);
                        lanes_q  <= lane_e'(req_lanes);
                        dv_q     <= dv_w;
                        grp_q    <= '0;
                        st_q     <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    part_q <= 1'b0;
                    if (int'(hdr_q) <= ABYTES) begin
                        lo_byte_q <= hdr_byte;
                        hi_byte_q <= hdr_byte;
                        drive_q   <= 1'b1;
                        rd_q      <= 1'b0;
                        load_q    <= 1'b1;
                        hdr_q     <= hdr_q + 1'b1;
                        st_q      <= ST_SHIFT;
                    end else if (left_q != '0) begin
                        left_q <= left_q - 1'b1;
                        if (write_q) begin
                            st_q <= ST_FETCH;
                        end else begin
                            drive_q <= 1'b0;
                            rd_q    <= 1'b1;
                            load_q  <= 1'b1;
                            st_q    <= ST_SHIFT;
                        end
                    end else begin
                        drive_q <= 1'b0;
                        gap_q   <= '0;
                        st_q    <= ST_GAP;
                    end
                end
                ST_FETCH: if (tx_valid) begin
                    if (stripe_q && !part_q) begin
                        lo_byte_q <= tx_data;
                        part_q    <= 1'b1;
                    end else begin
                        if (!stripe_q) lo_byte_q <= tx_data;
                        hi_byte_q <= tx_data;
                        drive_q   <= 1'b1;
                        rd_q      <= 1'b0;
                        load_q    <= 1'b1;
                        st_q      <= ST_SHIFT;
                    end
                end
                ST_SHIFT: if (fall_w) begin
                    if (grp_end) begin
                        grp_q  <= '0;
                        part_q <= 1'b0;
                        st_q   <= rd_q ? ST_DRAIN : ST_NEXT;
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                ST_DRAIN: if (rx_ready) begin
                    if (stripe_q && !part_q) part_q <= 1'b1;
                    else                     st_q   <= ST_NEXT;
                end
                ST_GAP: begin
                    if (gap_q == dv_q - 1'b1) st_q <= ST_IDLE;
                    else                      gap_q <= gap_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dps_stripe_engine_chk.sv
// Port-level checker for the shift engine, attached with bind.
// It keeps a saturating count of cycles with cs_n high so that
// the select gap can be checked without a deep history window.
module dps_stripe_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       cs_n,
    input logic [3:0] lo_oe,
    input logic [3:0] up_oe,
    input logic       rx_valid,
    input logic       err
);
    logic [3:0] hi_cnt;

    // Saturating count of cycles spent with the select released
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_cnt <= 4'hF;
        else if (!cs_n) hi_cnt <= '0;
        else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R2
    AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((lo_oe != 4'b0) || (up_oe != 4'b0)) |-> !cs_n); // R4
    AST_LO_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_oe != 4'b0) |-> (lo_oe == 4'b0001 || lo_oe == 4'b0011 || lo_oe == 4'b1111)); // R8
    AST_UP_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_oe != 4'b0) |-> (up_oe == 4'b0001 || up_oe == 4'b0011 || up_oe == 4'b1111)); // R8
    AST_REJECT_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && $past(cs_n))); // R9
    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R9
    AST_RX_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cs_n); // R6
    AST_SELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 4'd2)); // R11
endmodule

bind dps_stripe_engine dps_stripe_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .lo_oe   (lo_dq_oe),
    .up_oe   (up_dq_oe),
    .rx_valid(rx_valid),
    .err     (req_err)
);

// File: tb/dps_stripe_engine_bench.sv
// Scoreboard bench: the request task pushes the expected bytes of
// each bus and of the read stream; monitors pop and compare them.
module dps_stripe_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HDR_BITS   = 32;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] clk_div = 8'd2;
    logic       req_valid = 1'b0, req_ready, req_write = 1'b0, req_stripe = 1'b0, req_err;
    logic [7:0] req_cmd = '0;
    logic [23:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic [1:0] req_bus = 2'b11, req_lanes = 2'd0;
    logic       tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1;
    logic [7:0] tx_data = '0, rx_data;
    logic       sclk, cs_n;
    logic [3:0] lo_dq_o, lo_dq_oe, lo_dq_i, up_dq_o, up_dq_oe, up_dq_i;

    int n_chk = 0, n_bad = 0;
    int cur_lanes = 0, exp_half = 1, prev_div = 0, fcnt = 0, cyc = 0;
    bit rx_bp = 1'b0, take_flag = 1'b0, cs_low_seen = 1'b0, finished = 1'b0;
    logic [7:0] exp_lo[$], exp_up[$], exp_rx[$], tx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dps_stripe_engine u_dps_stripe_engine (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .req_bus(req_bus), .req_stripe(req_stripe), .req_lanes(req_lanes),
        .req_err(req_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .sclk(sclk), .cs_n(cs_n),
        .lo_dq_o(lo_dq_o), .lo_dq_oe(lo_dq_oe), .lo_dq_i(lo_dq_i),
        .up_dq_o(up_dq_o), .up_dq_oe(up_dq_oe), .up_dq_i(up_dq_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int bus, input int k);
        return (bus == 0) ? 8'(8'hC5 + 29 * k) : 8'(8'h5A + 37 * k);
    endfunction

    // Flash model output: group index = falling edges since select
    function automatic logic [3:0] flash_out(input int bus, input int f);
        int w, gpb, d, g;
        logic [7:0] p;
        w = 1 << cur_lanes;
        gpb = 8 / w;
        d = f - HDR_BITS / w;
        if (d < 0) return 4'b0;
        p = pat(bus, d / gpb);
        g = d % gpb;
        if (w == 4) return (g == 0) ? p[7:4] : p[3:0];
        if (w == 2) return {2'b0, p[7-2*g -: 2]};
        return {2'b0, p[7-g], 1'b0};
    endfunction

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) fcnt = 0;
        else      fcnt = fcnt + 1;
    end
    assign lo_dq_i = flash_out(0, fcnt);
    assign up_dq_i = flash_out(1, fcnt);

    // Bus monitors: rebuild driven bytes on rising sclk (R3 R4 R5 R8)
    logic [7:0] acc_lo = '0, acc_up = '0;
    int nb_lo = 0, nb_up = 0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            nb_lo = 0; nb_up = 0;
        end else begin
            int w;
            w = 1 << cur_lanes;
            if (lo_dq_oe != 4'b0) begin
                acc_lo = (w == 4) ? {acc_lo[3:0], lo_dq_o} :
                         (w == 2) ? {acc_lo[5:0], lo_dq_o[1:0]} : {acc_lo[6:0], lo_dq_o[0]};
                nb_lo += w;
                if (nb_lo == 8) begin
                    nb_lo = 0;
                    if (exp_lo.size() == 0) check(0, "R4 lower bus unexpected byte", acc_lo, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_lo.pop_front();
                        check(acc_lo == e, "R3/R5/R8 lower bus byte", acc_lo, e);
                    end
                end
            end
            if (up_dq_oe != 4'b0) begin
                acc_up = (w == 4) ? {acc_up[3:0], up_dq_o} :
                         (w == 2) ? {acc_up[5:0], up_dq_o[1:0]} : {acc_up[6:0], up_dq_o[0]};
                nb_up += w;
                if (nb_up == 8) begin
                    nb_up = 0;
                    if (exp_up.size() == 0) check(0, "R4 upper bus unexpected byte", acc_up, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_up.pop_front();
                        check(acc_up == e, "R3/R5/R8 upper bus byte", acc_up, e);
                    end
                end
            end
        end
    end

    // Cycle monitor away from the edge: streams, clock shape, gap
    int hc = 0, hi_n = 100;
    always @(negedge clk) begin
        cyc++;
        if (!cs_n) cs_low_seen = 1'b1;
        if (rst_n) begin
            if (cs_n && sclk) check(0, "R2 sclk high while deselected", 1, 0);
            if (sclk) hc++;
            else if (hc > 0) begin
                check(hc == exp_half, "R10 sclk high time", hc, exp_half);
                hc = 0;
            end
            if (cs_n) hi_n++;
            else begin
                if (hi_n > 0 && prev_div > 0) check(hi_n >= prev_div, "R11 select gap", hi_n, prev_div);
                hi_n = 0;
            end
        end
        if (take_flag) void'(tx_q.pop_front());
        tx_valid  = (tx_q.size() > 0);
        tx_data   = tx_valid ? tx_q[0] : 8'h00;
        take_flag = tx_valid && tx_ready;
        rx_ready  = rx_bp ? ((cyc % 3) != 0) : 1'b1;
        if (rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) check(0, "R6/R7 unexpected read byte", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_data == e, "R6/R7 read byte", rx_data, e);
            end
        end
    end

    task automatic run_req(input logic [7:0] cmd, input logic [23:0] addr, input int len,
                           input bit wr, input logic [1:0] bus, input bit st,
                           input int ln, input int div, input string tag);
        logic [23:0] ea;
        logic [1:0]  act;
        int d;
        d = (div < 2) ? 2 : (div & ~1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_lanes = ln;
        exp_half  = d / 2;
        ea  = st ? (addr >> 1) : addr;
        act = (st || bus == 2'b00) ? 2'b11 : bus;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] hb;
            hb = (i == 0) ? cmd : ea[8*(3-i) +: 8];
            if (act[0]) exp_lo.push_back(hb);
            if (act[1]) exp_up.push_back(hb);
        end
        if (wr) begin
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                b = 8'(8'h11 + 53 * i + cmd);
                tx_q.push_back(b);
                if (st) begin
                    if (i % 2 == 0) exp_lo.push_back(b); else exp_up.push_back(b);
                end else begin
                    if (act[0]) exp_lo.push_back(b);
                    if (act[1]) exp_up.push_back(b);
                end
            end
        end else begin
            for (int k = 0; k < (st ? len / 2 : len); k++) begin
                if (st) begin exp_rx.push_back(pat(0, k)); exp_rx.push_back(pat(1, k)); end
                else exp_rx.push_back((act == 2'b10) ? pat(1, k) : pat(0, k));
            end
        end
        clk_div = 8'(div); req_cmd = cmd; req_addr = addr; req_len = 12'(len);
        req_write = wr; req_bus = bus; req_stripe = st; req_lanes = 2'(ln);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b0, "R9 no error on legal request", req_err, 0);
        while (!req_ready) @(negedge clk);
        prev_div = d;
        repeat (3) @(negedge clk);
        check(exp_lo.size() == 0, {tag, " lower bus bytes all seen"}, exp_lo.size(), 0);
        check(exp_up.size() == 0, {tag, " upper bus bytes all seen"}, exp_up.size(), 0);
        check(exp_rx.size() == 0, {tag, " read bytes all seen"}, exp_rx.size(), 0);
        check(tx_q.size() == 0, {tag, " write bytes all taken"}, tx_q.size(), 0);
        exp_lo.delete(); exp_up.delete(); exp_rx.delete(); tx_q.delete();
    endtask

    task automatic reject_req(input logic [23:0] addr, input int len, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cs_low_seen = 1'b0;
        req_addr = addr; req_len = 12'(len); req_stripe = 1'b1; req_write = 1'b1;
        req_bus = 2'b11; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, {tag, " error pulse"}, req_err, 1);
        @(negedge clk);
        check(req_err == 1'b0, {tag, " error is one cycle"}, req_err, 0);
        repeat (20) @(negedge clk);
        check(!cs_low_seen, {tag, " select never asserted"}, cs_low_seen, 0);
        check(req_ready == 1'b1, {tag, " engine idle"}, req_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        check(lo_dq_oe == 4'b0 && up_dq_oe == 4'b0, "R1 enables after reset", {lo_dq_oe, up_dq_oe}, 0);
        check(req_err == 1'b0 && req_ready == 1'b1, "R1 err/ready after reset", {req_err, req_ready}, 1);

        run_req(8'h6B, 24'h123456, 3, 1'b1, 2'b11, 1'b0, 2, 2, "R4 mirror quad write");
        run_req(8'h02, 24'hABCDEF, 2, 1'b1, 2'b01, 1'b0, 0, 4, "R4 lower single write");
        run_req(8'h32, 24'h00F0F1, 2, 1'b1, 2'b10, 1'b0, 1, 6, "R4 upper dual write");
        run_req(8'h38, 24'h02468A, 4, 1'b1, 2'b00, 1'b1, 2, 3, "R5 striped quad write");
        run_req(8'h12, 24'h7FFFFE, 6, 1'b1, 2'b01, 1'b1, 0, 2, "R5 striped single write");
        rx_bp = 1'b1;
        run_req(8'hBB, 24'h000100, 4, 1'b0, 2'b11, 1'b1, 1, 2, "R6 striped dual read");
        run_req(8'hEB, 24'h100000, 6, 1'b0, 2'b11, 1'b1, 2, 0, "R6 striped quad read");
        run_req(8'h03, 24'h000033, 3, 1'b0, 2'b11, 1'b0, 0, 2, "R7 mirror single read");
        rx_bp = 1'b0;
        run_req(8'h6C, 24'h000777, 2, 1'b0, 2'b10, 1'b0, 2, 4, "R7 upper quad read");
        run_req(8'h3B, 24'h000555, 2, 1'b0, 2'b01, 1'b0, 1, 2, "R7 lower dual read");

        reject_req(24'h000101, 4, "R9 odd address");
        reject_req(24'h000100, 3, "R9 odd length");
        reject_req(24'h000100, 0, "R9 zero length");
        run_req(8'h05, 24'h000002, 2, 1'b1, 2'b11, 1'b1, 2, 2, "R9 legal after reject");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule